// File: doc/BRIEF.md
# Link-Up Monitor with Speed-Change Stall Recovery

This block watches a link controller from outside it. Two 32-bit debug status words and a receive-valid flag from the PHY arrive each cycle. From them the block derives a qualified link-up flag. It also spots a speed change that has hung in the receiver-lock recovery state, and it recovers that stall by asking a PHY register access port to force two receive override enables on and, after a set time, off again. That port does the read-modify-write itself. The block only issues one-cycle set or clear requests and gives the register address and bit mask for them.

A bring-up timer runs from reset. If no qualified link-up has been seen when it expires, a sticky failure flag is raised and all monitoring stops. A saturating counter records how many stalls have been declared. Every delay is counted in clock cycles. It is set by a cycles-per-microsecond parameter and by durations in microseconds (stall settle about 2 ms, override pulse 3 ms).

Top module: `link_up_guard`

## Requirements
- R1: `linkUp` is 1 in the cycle after an edge at which `dbgWord1` bit 4 is 1 and `dbgWord1` bit 29 is 0. After an edge where either condition fails it is 0. This holds while no bring-up failure has occurred.
- R2: The link state is taken only from `dbgWord0[5:0]`, and the receiver-lock recovery state has code 6'h0D. All higher bits of `dbgWord0` have no effect on stall detection.
- R3: A stall is declared only once state 6'h0D has coincided with `rxValid` = 0 at SETTLE_US*CYC_PER_US consecutive clock edges. Any edge without that coincidence restarts the run. No run is counted while an override pulse is in progress.
- R4: When a stall is declared, `ovrdReq` = 1 with `ovrdSet` = 1 for exactly one cycle, starting the cycle after the declaring edge. The request targets `ovrdAddr` = 16'h1005 with `ovrdMask` = 16'h0028 (bit 5 is data enable, bit 3 is PLL enable).
- R5: A clear request (`ovrdReq` = 1, `ovrdSet` = 0) follows exactly PULSE_US*CYC_PER_US cycles after the set request, with no other request in between. Watching then resumes with a fresh run count, so a persisting stall is declared again.
- R6: `stuckCount` rises by one for each declared stall. It holds at 2^STUCK_W-1 instead of wrapping.
- R7: If no qualified link-up has been sampled by clock edge BOOT_US*CYC_PER_US after reset, `bringupFail` becomes 1 after that edge and stays 1. From then on `linkUp` stays 0 and no set request is issued.
- R8: If the bring-up timeout expires while an override pulse is in progress, a clear request is issued in the cycle that `bringupFail` rises.
- R9: While reset is asserted, `linkUp`, `ovrdReq`, `ovrdSet`, `bringupFail` and `stuckCount` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dbgWord0 | input | 32 | Debug word holding the link state in bits 5:0 |
| dbgWord1 | input | 32 | Debug word holding link-up (bit 4) and in-training (bit 29) |
| rxValid | input | 1 | PHY receive-valid flag |
| linkUp | output | 1 | Qualified link-up flag |
| ovrdReq | output | 1 | One-cycle request to the PHY register access port |
| ovrdSet | output | 1 | 1: set the masked bits, 0: clear them |
| ovrdAddr | output | 16 | PHY receive-override register address |
| ovrdMask | output | 16 | Bits to set or clear |
| stuckCount | output | STUCK_W | Saturating count of declared stalls |
| bringupFail | output | 1 | Sticky bring-up timeout flag |

## Verification
The assertions assume the debug words and `rxValid` are synchronous to `clk` and settle before each rising edge. They also assume the access port accepts every one-cycle request, so no request has to be held or repeated. The stimulus changes inputs only on falling edges. It holds each stall pattern for a counted number of edges, so every declaration, clear and timeout lands on a known edge. Timing parameters are shrunk so that saturation and a timeout in the middle of a pulse both occur within a short run.

// File: rtl/lug_pkg.sv
`timescale 1ns/1ps
package lug_pkg;
  localparam logic [15:0] RX_OVRD_ADDR   = 16'h1005;
  localparam int          RX_DATA_EN_BIT = 5;
  localparam int          RX_PLL_EN_BIT  = 3;
  localparam logic [5:0]  STATE_RCV_LOCK = 6'h0D;
  localparam int          LINK_UP_BIT    = 4;
  localparam int          IN_TRAIN_BIT   = 29;

  typedef enum logic [1:0] {
    ST_WATCH = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DEAD  = 2'd2
  } lugState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic settleInc;
    logic settleClr;
    logic pulseInc;
    logic pulseClr;
    logic bump;
    logic halt;
  } lugStrobe_t;
endpackage

// File: rtl/lug_datapath.sv
`timescale 1ns/1ps
module lug_datapath
  import lug_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned PULSE_CYC  = 6,
  parameter int unsigned BOOT_CYC   = 100,
  parameter int unsigned STUCK_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        dbgWord0,
  input  logic [31:0]        dbgWord1,
  input  logic               rxValid,
  input  lugStrobe_t         strobe,
  output logic               stallNow,
  output logic               linkQual,
  output logic               settleDone,
  output logic               pulseDone,
  output logic               bootExpired,
  output logic               linkUp,
  output logic [STUCK_W-1:0] stuckCount
);
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int PUL_W  = $clog2(PULSE_CYC + 1);
  localparam int BOOT_W = $clog2(BOOT_CYC + 1);
  localparam logic [STUCK_W-1:0] STUCK_MAX = {STUCK_W{1'b1}};

  logic [SET_W-1:0]  settleCnt;
  logic [PUL_W-1:0]  pulseCnt;
  logic [BOOT_W-1:0] bootCnt;
  logic              linkSeen;
  logic              unusedDbg;

  assign unusedDbg   = ^dbgWord0[31:6];
  assign stallNow    = (dbgWord0[5:0] == STATE_RCV_LOCK) && !rxValid;
  assign linkQual    = dbgWord1[LINK_UP_BIT] && !dbgWord1[IN_TRAIN_BIT];
  assign settleDone  = (settleCnt == SET_W'(SETTLE_CYC - 1));
  assign pulseDone   = (pulseCnt == PUL_W'(PULSE_CYC - 1));
  assign bootExpired = !linkSeen && (bootCnt == BOOT_W'(BOOT_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      pulseCnt  <= '0;
      bootCnt   <= '0;
      linkSeen  <= 1'b0;
      linkUp    <= 1'b0;
      stuckCount <= '0;
    end else begin
      if (strobe.settleClr)     settleCnt <= '0;
      else if (strobe.settleInc) settleCnt <= settleCnt + 1'b1;

      if (strobe.pulseClr)      pulseCnt <= '0;
      else if (strobe.pulseInc) pulseCnt <= pulseCnt + 1'b1;

      if (!linkSeen && !strobe.halt) bootCnt <= bootCnt + 1'b1;
      if (linkQual && !strobe.halt)  linkSeen <= 1'b1;

      linkUp <= strobe.halt ? 1'b0 : linkQual;

      if (strobe.bump && stuckCount != STUCK_MAX) stuckCount <= stuckCount + 1'b1;
    end
  end

  p_link_qual_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.halt && linkQual) |=> linkUp);
  p_link_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !linkQual |=> !linkUp);
  p_link_dead_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.halt |=> !linkUp);
  p_stuck_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bump && stuckCount != STUCK_MAX) |=> stuckCount == $past(stuckCount) + 1'b1);
  p_stuck_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stuckCount == STUCK_MAX) |=> stuckCount == STUCK_MAX);
endmodule

// File: rtl/lug_control.sv
`timescale 1ns/1ps
module lug_control
  import lug_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stallNow,
  input  logic       linkQual,
  input  logic       settleDone,
  input  logic       pulseDone,
  input  logic       bootExpired,
  output lugStrobe_t strobe,
  output logic       ovrdReq,
  output logic       ovrdSet,
  output logic       bringupFail
);
  lugState_t state, nextState;
  logic fireSet, fireClr, timeoutNow;

  assign timeoutNow  = bootExpired && !linkQual;
  assign bringupFail = (state == ST_DEAD);

  always_comb begin
    strobe    = '0;
    nextState = state;
    fireSet   = 1'b0;
    fireClr   = 1'b0;
    unique case (state)
      ST_WATCH: begin
        if (timeoutNow) begin
          nextState        = ST_DEAD;
          strobe.halt      = 1'b1;
          strobe.settleClr = 1'b1;
        end else if (stallNow) begin
          if (settleDone) begin
            fireSet          = 1'b1;
            strobe.bump      = 1'b1;
            strobe.settleClr = 1'b1;
            strobe.pulseClr  = 1'b1;
            nextState        = ST_HOLD;
          end else begin
            strobe.settleInc = 1'b1;
          end
        end else begin
          strobe.settleClr = 1'b1;
        end
      end
      ST_HOLD: begin
        if (timeoutNow) begin
          nextState   = ST_DEAD;
          fireClr     = 1'b1;
          strobe.halt = 1'b1;
        end else if (pulseDone) begin
          fireClr          = 1'b1;
          strobe.settleClr = 1'b1;
          nextState        = ST_WATCH;
        end else begin
          strobe.pulseInc = 1'b1;
        end
      end
      default: strobe.halt = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WATCH;
      ovrdReq <= 1'b0;
      ovrdSet <= 1'b0;
    end else begin
      state   <= nextState;
      ovrdReq <= fireSet || fireClr;
      ovrdSet <= fireSet;
    end
  end

  p_set_needs_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ovrdReq && ovrdSet) |-> $past(stallNow));
  p_single_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovrdReq && ovrdSet) |=> !(ovrdReq && ovrdSet));
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    bringupFail |=> bringupFail);
  p_no_set_dead_r7: assert property (@(posedge clk) disable iff (!rstN)
    bringupFail |-> !(ovrdReq && ovrdSet));
  p_clear_on_death_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(bringupFail) && $past(state) == ST_HOLD) |-> (ovrdReq && !ovrdSet));
endmodule

// File: rtl/link_up_guard.sv
`timescale 1ns/1ps
module link_up_guard
  import lug_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned SETTLE_US  = 2000,
  parameter int unsigned PULSE_US   = 3000,
  parameter int unsigned BOOT_US    = 100000,
  parameter int unsigned STUCK_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        dbgWord0,
  input  logic [31:0]        dbgWord1,
  input  logic               rxValid,
  output logic               linkUp,
  output logic               ovrdReq,
  output logic               ovrdSet,
  output logic [15:0]        ovrdAddr,
  output logic [15:0]        ovrdMask,
  output logic [STUCK_W-1:0] stuckCount,
  output logic               bringupFail
);
  localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int unsigned PULSE_CYC  = PULSE_US * CYC_PER_US;
  localparam int unsigned BOOT_CYC   = BOOT_US * CYC_PER_US;

  lugStrobe_t strobe;
  logic stallNow, linkQual, settleDone, pulseDone, bootExpired;

  assign ovrdAddr = RX_OVRD_ADDR;
  assign ovrdMask = (16'd1 << RX_DATA_EN_BIT) | (16'd1 << RX_PLL_EN_BIT);

  lug_datapath #(
    .SETTLE_CYC(SETTLE_CYC), .PULSE_CYC(PULSE_CYC),
    .BOOT_CYC(BOOT_CYC), .STUCK_W(STUCK_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .dbgWord0(dbgWord0), .dbgWord1(dbgWord1),
    .rxValid(rxValid), .strobe(strobe), .stallNow(stallNow),
    .linkQual(linkQual), .settleDone(settleDone), .pulseDone(pulseDone),
    .bootExpired(bootExpired), .linkUp(linkUp), .stuckCount(stuckCount)
  );

  lug_control i_ctl (
    .clk(clk), .rstN(rstN), .stallNow(stallNow), .linkQual(linkQual),
    .settleDone(settleDone), .pulseDone(pulseDone), .bootExpired(bootExpired),
    .strobe(strobe), .ovrdReq(ovrdReq), .ovrdSet(ovrdSet),
    .bringupFail(bringupFail)
  );
endmodule

// File: tb/test_link_up_guard.sv
`timescale 1ns/1ps
module test_link_up_guard;
  // shrunk timing: settle 4, pulse 6, bring-up limit 97 cycles, saturation at 7
  localparam int STUCK_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] dbgWord0 = '0, dbgWord1 = '0;
  logic rxValid = 1'b1;
  logic linkUp, ovrdReq, ovrdSet, bringupFail;
  logic [15:0] ovrdAddr, ovrdMask;
  logic [STUCK_W-1:0] stuckCount;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  link_up_guard #(
    .CYC_PER_US(1), .SETTLE_US(4), .PULSE_US(6), .BOOT_US(97), .STUCK_W(STUCK_W)
  ) i_link_up_guard (
    .clk(clk), .rstN(rstN), .dbgWord0(dbgWord0), .dbgWord1(dbgWord1),
    .rxValid(rxValid), .linkUp(linkUp), .ovrdReq(ovrdReq), .ovrdSet(ovrdSet),
    .ovrdAddr(ovrdAddr), .ovrdMask(ovrdMask), .stuckCount(stuckCount),
    .bringupFail(bringupFail)
  );

  // {dbgWord0, dbgWord1, rxValid, expected linkUp}
  localparam logic [65:0] VECS [8] = '{
    {32'h0000_0000, 32'h0000_0010, 1'b1, 1'b1},
    {32'h0000_0000, 32'h2000_0010, 1'b1, 1'b0},
    {32'h0000_000D, 32'h2000_0000, 1'b1, 1'b0},
    {32'h0000_000C, 32'h0000_0000, 1'b0, 1'b0},
    {32'h0000_0000, 32'hFFFF_FFEF, 1'b1, 1'b0},
    {32'h0000_000D, 32'hDFFF_FFFF, 1'b1, 1'b1},
    {32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {32'hFFFF_FF00, 32'h0000_0010, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; dbgWord0 = '0; dbgWord1 = '0; rxValid = 1'b1;
    tick(2);
    check("R9 linkUp", linkUp, 0);
    check("R9 ovrdReq", ovrdReq, 0);
    check("R9 ovrdSet", ovrdSet, 0);
    check("R9 stuckCount", stuckCount, 0);
    check("R9 bringupFail", bringupFail, 0);
    rstN = 1'b1;
  endtask

  task automatic setStall(input logic on);
    dbgWord0 = on ? 32'hFFFF_FFCD : 32'h0000_0000;  // R2: high bits set, low 6 = 0x0D
    rxValid  = !on;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();

    // R1 table walk; first vector also records link-up so no timeout later
    foreach (VECS[i]) begin
      dbgWord0 = VECS[i][65:34];
      dbgWord1 = VECS[i][33:2];
      rxValid  = VECS[i][1];
      tick(1);
      check("R1 linkUp", linkUp, VECS[i][0]);
      check("R3 no request", ovrdReq, 0);
    end

    // R2: other state with rxValid low never stalls; R3: 0x0D with rxValid high neither
    dbgWord0 = 32'h0000_000C; rxValid = 1'b0;
    for (int k = 0; k < 10; k++) begin tick(1); check("R2 wrong state", ovrdReq, 0); end
    dbgWord0 = 32'h0000_000D; rxValid = 1'b1;
    for (int k = 0; k < 10; k++) begin tick(1); check("R3 rxValid high", ovrdReq, 0); end

    // R4 declaration after 4 consecutive stalled edges
    setStall(1'b1);
    tick(3);
    check("R3 early", ovrdReq, 0);
    tick(1);
    check("R4 req", ovrdReq, 1);
    check("R4 set", ovrdSet, 1);
    check("R4 addr", ovrdAddr, 32'h1005);
    check("R4 mask", ovrdMask, 32'h0028);
    check("R6 count1", stuckCount, 1);
    tick(1);
    check("R4 single cycle", ovrdReq, 0);
    tick(4);
    check("R5 no early clear", ovrdReq, 0);
    tick(1);
    check("R5 clear req", ovrdReq, 1);
    check("R5 clear kind", ovrdSet, 0);
    tick(3);
    check("R5 fresh run", ovrdReq, 0);
    tick(1);
    check("R5 redeclare", ovrdReq & ovrdSet, 1);
    check("R6 count2", stuckCount, 2);

    // R6 saturation: six more declarations
    tick(60);
    check("R6 last set", ovrdReq & ovrdSet, 1);
    check("R6 saturate", stuckCount, 7);

    // R3 broken run restarts
    setStall(1'b0);
    tick(10);
    setStall(1'b1);
    tick(3);
    setStall(1'b0);
    tick(1);
    check("R3 break", ovrdReq, 0);
    setStall(1'b1);
    tick(3);
    check("R3 restart early", ovrdReq, 0);
    tick(1);
    check("R3 restart fire", ovrdReq & ovrdSet, 1);
    check("R6 held", stuckCount, 7);

    // R7 timeout with no qualified link
    doReset();
    dbgWord1 = 32'h2000_0010;
    tick(96);
    check("R7 before limit", bringupFail, 0);
    tick(1);
    check("R7 fail", bringupFail, 1);
    check("R7 linkUp", linkUp, 0);
    dbgWord1 = 32'h0000_0010;
    tick(2);
    check("R7 linkUp frozen", linkUp, 0);
    setStall(1'b1);
    tick(8);
    check("R7 no request", ovrdReq, 0);
    check("R7 no count", stuckCount, 0);
    check("R7 sticky", bringupFail, 1);

    // R8 timeout in the middle of a pulse (sets at edges 4,14..94, limit 97)
    doReset();
    setStall(1'b1);
    tick(4);
    check("R4 from reset", ovrdReq & ovrdSet, 1);
    tick(92);
    check("R8 before limit", bringupFail, 0);
    tick(1);
    check("R8 fail", bringupFail, 1);
    check("R8 clear req", ovrdReq, 1);
    check("R8 clear kind", ovrdSet, 0);
    check("R6 saturate again", stuckCount, 7);
    tick(11);
    check("R8 quiet after", ovrdReq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule